// File: doc/BRIEF.md
# Asynchronous Byte FIFO Port Controller

This block is the FPGA-side master for a byte-wide, handshake-paced FIFO port on an external USB bridge device. Inside the chip it offers two valid/ready byte streams: bytes pulled from the device come out on the receive stream, and bytes offered on the transmit stream are pushed into the device. Outside the chip it drives an active-low read strobe, an active-low write strobe and an active-low send-immediate/wakeup strobe. It watches two active-low flags, "byte available" and "space available", and shares one 8-bit data bus with the device. The bus is split into an input, an output and an output-enable.

Both flags pass through two-flop synchronizers. Every strobe timing is counted in system-clock cycles. The write data setup, the strobe low width and the point at which read data is sampled are parameters. The device drops its byte-available flag after every read and takes some time to update its space flag after a write. For that reason, after any strobe is released the controller ignores both flags for a fixed number of cycles. When both directions could go, reads and writes take turns. A one-cycle request pulses the send-immediate strobe low. The device uses that strobe to flush pending transmit data or, while suspended, to ask for a bus resume.

Top module: `fifo_port_ctrl`

## Requirements
- R1: While reset is asserted, the read, write and send-immediate strobes are high, the bus output-enable is low, and rx_valid and tx_ready are low.
- R2: A read strobe falls only after the synchronized byte-available flag was seen low while no received byte is waiting. The captured byte is presented on rx_data with rx_valid high and stays unchanged until rx_ready is seen. No further read starts while a byte is waiting.
- R3: The read strobe stays low for exactly max(STROBE_W, CAPTURE_W) cycles, and the bus is sampled at the edge that ends the CAPTURE_W-th low cycle.
- R4: After a read or write strobe rises, the block waits at least HOLD_W+1 cycles, with no strobe low and the bus not driven, before the next strobe or bus drive begins.
- R5: A write begins only when tx_valid is high and the synchronized space-available flag was seen low. tx_ready is high for exactly the cycle in which the byte is taken. Bytes reach the device in the order they were accepted.
- R6: A write drives the byte on bus_out with bus_oe high and the write strobe high for exactly SETUP_W cycles. The write strobe is then low for exactly STROBE_W cycles while the same byte stays driven. The device takes the byte on the falling edge of the write strobe.
- R7: bus_oe is never high while the read strobe is low, and it is low in the cycle before any read strobe falls.
- R8: When both directions are allowed in the same cycle, the direction not used last is chosen, so that under continuous demand reads and writes strictly alternate.
- R9: A cycle with flush_req high while the send-immediate strobe is high drives that strobe low for exactly PULSE_W cycles, starting in the next cycle. Requests made while the strobe is already low are ignored.
- R10: The read and write strobes are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | output | DW | Byte read from the device |
| rx_valid | output | 1 | rx_data holds a byte |
| rx_ready | input | 1 | Consumer takes the byte |
| tx_data | input | DW | Byte to write to the device |
| tx_valid | input | 1 | tx_data holds a byte |
| tx_ready | output | 1 | Byte on tx_data is taken this cycle |
| flush_req | input | 1 | Request a send-immediate/wakeup pulse |
| ext_avail_n | input | 1 | Device flag, low when a byte can be read |
| ext_space_n | input | 1 | Device flag, low when a byte can be written |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |
| ext_flush_n | output | 1 | Send-immediate/wakeup strobe, active low |
| bus_in | input | DW | Data bus as seen from the pins |
| bus_out | output | DW | Data to drive onto the bus |
| bus_oe | output | 1 | Enable of the bus driver |

## Verification
The assertions assume the following about the device:
- It raises its byte-available flag within one cycle after the read strobe rises.
- It holds bus_in stable for as long as the read strobe is low.
- The rx and tx streams obey the usual valid/ready rule that a presented item is not withdrawn.

The device model in the bench reacts to a rising read strobe on the next half cycle. It drives bus_in from its head byte only while the read strobe is low. Its flags change only on the falling clock edge. The stimulus holds tx_valid and tx_data until tx_ready is seen and changes rx_ready only between edges.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WSET = 2'd2,
    ST_WLOW = 2'd3
  } fpc_state_e;

  // Length of the read strobe: long enough for both the width and the capture point.
  function automatic int unsigned fpc_rd_len(input int unsigned strobe_w,
                                             input int unsigned capture_w);
    return (strobe_w > capture_w) ? strobe_w : capture_w;
  endfunction

  function automatic int unsigned fpc_max3(input int unsigned a, input int unsigned b,
                                           input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Round-robin pick: returns {write, read}; last_rd tells which side went last.
  function automatic logic [1:0] fpc_pick(input logic rd_ok, input logic wr_ok,
                                          input logic last_rd);
    logic rd;
    logic wr;
    rd = rd_ok && (!wr_ok || !last_rd);
    wr = wr_ok && !rd;
    return {wr, rd};
  endfunction

endpackage

// File: rtl/fpc_sync.sv
module fpc_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= {W{RST_VAL}};
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) stg[s] <= {W{RST_VAL}};
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/fpc_holdoff.sv
module fpc_holdoff #(
  parameter int HOLD_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic quiet
);
  localparam int HW = $clog2(HOLD_W + 2);
  logic [HW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= HW'(HOLD_W);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign quiet = (cnt == '0);
endmodule

// File: rtl/fpc_pulse.sv
module fpc_pulse #(
  parameter int PULSE_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic pulse_n
);
  localparam int PW = $clog2(PULSE_W + 1);
  logic [PW-1:0] cnt;
  logic          busy;

  assign busy = (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (busy)       cnt <= cnt - 1'b1;
    else if (req)        cnt <= PW'(PULSE_W);
  end

  assign pulse_n = !busy;
endmodule

// File: rtl/fifo_port_ctrl.sv
module fifo_port_ctrl
  import fpc_pkg::*;
#(
  parameter int DW        = 8,
  parameter int STROBE_W  = 3,
  parameter int SETUP_W   = 3,
  parameter int CAPTURE_W = 3,
  parameter int HOLD_W    = 4,
  parameter int PULSE_W   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  input  logic          rx_ready,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic          flush_req,
  input  logic          ext_avail_n,
  input  logic          ext_space_n,
  output logic          ext_rd_n,
  output logic          ext_wr_n,
  output logic          ext_flush_n,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe
);
  localparam int unsigned RD_LEN  = fpc_rd_len(STROBE_W, CAPTURE_W);
  localparam int unsigned CNT_TOP = fpc_max3(RD_LEN, SETUP_W, STROBE_W);
  localparam int          CW      = $clog2(CNT_TOP + 1);

  fpc_state_e    state;
  logic [CW-1:0] cnt;
  logic [DW-1:0] wbyte;
  logic [DW-1:0] rx_q;
  logic          rx_full;
  logic          last_rd;

  // Named internal events, used by the bound checker.
  logic [1:0] flags_n;
  logic       flag_avail;
  logic       flag_space;
  logic       quiet;
  logic       rd_ok, wr_ok;
  logic [1:0] pick;
  logic       rd_start, wr_start;
  logic       capture_evt;
  logic       strobe_release;

  fpc_sync #(.W(2), .STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d   ({ext_space_n, ext_avail_n}),
    .q   (flags_n)
  );

  assign flag_avail = !flags_n[0];
  assign flag_space = !flags_n[1];

  fpc_holdoff #(.HOLD_W(HOLD_W)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (strobe_release),
    .quiet (quiet)
  );

  fpc_pulse #(.PULSE_W(PULSE_W)) u_flush (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (flush_req),
    .pulse_n (ext_flush_n)
  );

  assign rd_ok    = flag_avail && !rx_full && quiet;
  assign wr_ok    = tx_valid && flag_space && quiet;
  assign pick     = fpc_pick(rd_ok, wr_ok, last_rd);
  assign rd_start = (state == ST_IDLE) && pick[0];
  assign wr_start = (state == ST_IDLE) && pick[1];

  assign capture_evt    = (state == ST_RD) && (cnt == CW'(CAPTURE_W - 1));
  assign strobe_release = ((state == ST_RD)   && (cnt == CW'(RD_LEN - 1))) ||
                          ((state == ST_WLOW) && (cnt == CW'(STROBE_W - 1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      wbyte   <= '0;
      last_rd <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (rd_start) begin
            state   <= ST_RD;
            last_rd <= 1'b1;
          end else if (wr_start) begin
            state   <= ST_WSET;
            wbyte   <= tx_data;
            last_rd <= 1'b0;
          end
        end
        ST_RD: begin
          if (strobe_release) state <= ST_IDLE;
          else                cnt   <= cnt + 1'b1;
        end
        ST_WSET: begin
          if (cnt == CW'(SETUP_W - 1)) begin
            state <= ST_WLOW;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WLOW: begin
          if (strobe_release) state <= ST_IDLE;
          else                cnt   <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_full <= 1'b0;
      rx_q    <= '0;
    end else if (capture_evt) begin
      rx_full <= 1'b1;
      rx_q    <= bus_in;
    end else if (rx_full && rx_ready) begin
      rx_full <= 1'b0;
    end
  end

  assign rx_data  = rx_q;
  assign rx_valid = rx_full;
  assign tx_ready = wr_start;
  assign ext_rd_n = (state != ST_RD);
  assign ext_wr_n = (state != ST_WLOW);
  assign bus_oe   = (state == ST_WSET) || (state == ST_WLOW);
  assign bus_out  = wbyte;

endmodule

// File: rtl/fpc_checks.sv
module fpc_checks
  import fpc_pkg::*;
#(
  parameter int DW        = 8,
  parameter int STROBE_W  = 3,
  parameter int SETUP_W   = 3,
  parameter int CAPTURE_W = 3,
  parameter int PULSE_W   = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ext_rd_n,
  input logic          ext_wr_n,
  input logic          ext_flush_n,
  input logic          bus_oe,
  input logic [DW-1:0] bus_out,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic [DW-1:0] rx_data,
  input logic          tx_valid,
  input logic          flag_avail,
  input logic          flag_space
);
  localparam int unsigned RD_LEN = fpc_rd_len(STROBE_W, CAPTURE_W);
  localparam int unsigned TOP    = fpc_max3(RD_LEN, SETUP_W, PULSE_W);
  localparam int          KW     = $clog2(TOP + 2);
  localparam logic [KW-1:0] SAT  = KW'(TOP + 1);

  logic [KW-1:0] rd_lo, setup_c, fl_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_lo   <= '0;
      setup_c <= '0;
      fl_lo   <= '0;
    end else begin
      rd_lo   <= !ext_rd_n ? ((rd_lo == SAT) ? rd_lo : rd_lo + 1'b1) : '0;
      setup_c <= (bus_oe && ext_wr_n) ? ((setup_c == SAT) ? setup_c : setup_c + 1'b1) : '0;
      fl_lo   <= !ext_flush_n ? ((fl_lo == SAT) ? fl_lo : fl_lo + 1'b1) : '0;
    end
  end

  a_r2_read_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_rd_n) |-> $past(flag_avail) && !$past(rx_valid));

  a_r2_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));

  a_r3_read_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_rd_n) |-> rd_lo == KW'(RD_LEN));

  a_r4_quiet_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ext_rd_n) || $rose(ext_wr_n)) |=> ext_rd_n && ext_wr_n && !bus_oe);

  a_r5_write_needs_space: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> $past(flag_space) && $past(tx_valid));

  a_r6_setup_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_wr_n) |-> setup_c == KW'(SETUP_W));

  a_r6_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_wr_n |-> bus_oe && $stable(bus_out));

  a_r7_no_drive_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_oe && !ext_rd_n));

  a_r7_release_before_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_rd_n) |-> !$past(bus_oe));

  a_r9_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_flush_n) |-> fl_lo == KW'(PULSE_W));

  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ext_rd_n && !ext_wr_n));

endmodule

bind fifo_port_ctrl fpc_checks #(
  .DW(DW), .STROBE_W(STROBE_W), .SETUP_W(SETUP_W),
  .CAPTURE_W(CAPTURE_W), .PULSE_W(PULSE_W)
) i_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .ext_rd_n    (ext_rd_n),
  .ext_wr_n    (ext_wr_n),
  .ext_flush_n (ext_flush_n),
  .bus_oe      (bus_oe),
  .bus_out     (bus_out),
  .rx_valid    (rx_valid),
  .rx_ready    (rx_ready),
  .rx_data     (rx_data),
  .tx_valid    (tx_valid),
  .flag_avail  (flag_avail),
  .flag_space  (flag_space)
);

// File: tb/test_fifo_port_ctrl.sv
`timescale 1ns/100ps
module test_fifo_port_ctrl;
  localparam int DW = 8, STROBE_W = 3, SETUP_W = 3, CAPTURE_W = 3, HOLD_W = 4, PULSE_W = 3;
  localparam int RD_LEN = (STROBE_W > CAPTURE_W) ? STROBE_W : CAPTURE_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0] rx_data, tx_data = '0, bus_in, bus_out;
  logic rx_valid, rx_ready = 1'b1, tx_valid = 1'b0, tx_ready, flush_req = 1'b0;
  logic ext_avail_n = 1'b1, ext_space_n = 1'b0;
  logic ext_rd_n, ext_wr_n, ext_flush_n, bus_oe;

  always #2 clk = ~clk;

  fifo_port_ctrl #(.DW(DW), .STROBE_W(STROBE_W), .SETUP_W(SETUP_W), .CAPTURE_W(CAPTURE_W),
                   .HOLD_W(HOLD_W), .PULSE_W(PULSE_W)) i_fifo_port_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .flush_req(flush_req),
    .ext_avail_n(ext_avail_n), .ext_space_n(ext_space_n), .ext_rd_n(ext_rd_n),
    .ext_wr_n(ext_wr_n), .ext_flush_n(ext_flush_n), .bus_in(bus_in), .bus_out(bus_out),
    .bus_oe(bus_oe));

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Scoreboard queues: device contents, expected received bytes, expected written bytes.
  logic [DW-1:0] dev_q[$], exp_rx[$], exp_tx[$];
  logic [DW-1:0] dev_byte = '0;
  logic [7:0]    seq[$];
  bit rec = 1'b0;
  assign bus_in = ext_rd_n ? '0 : dev_byte;

  int rd_w, wr_w, setup_w, fl_w, idle_cnt, rd_starts, wr_starts, pulses;
  int viol_r7, viol_r10;
  bit prev_rd, prev_wr, prev_oe, prev_fl, prev_act, refill;

  // Device model and monitors, all on the falling edge.
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_rd = 1; prev_wr = 1; prev_oe = 0; prev_fl = 1; prev_act = 0; refill = 0;
      rd_w = 0; wr_w = 0; setup_w = 0; fl_w = 0; idle_cnt = 1000;
    end else begin
      if (!prev_rd && ext_rd_n) begin
        check(rd_w == RD_LEN, "R3 read strobe width", rd_w, RD_LEN);
        if (dev_q.size() != 0) void'(dev_q.pop_front());
        ext_avail_n = 1'b1;
        refill = 1;
      end else if (refill) begin
        refill = 0;
      end else begin
        ext_avail_n = (dev_q.size() == 0);
      end
      dev_byte = (dev_q.size() != 0) ? dev_q[0] : '0;
      rd_w = !ext_rd_n ? rd_w + 1 : 0;

      if (prev_rd && !ext_rd_n) begin
        rd_starts++;
        check(!prev_oe, "R7 bus released before read", prev_oe, 0);
        if (rec) seq.push_back("R");
      end
      if (!prev_oe && bus_oe) begin
        wr_starts++;
        if (rec) seq.push_back("W");
      end

      if (prev_wr && !ext_wr_n) begin
        check(setup_w == SETUP_W, "R6 setup cycles", setup_w, SETUP_W);
        if (exp_tx.size() == 0) check(0, "R5 unexpected write", bus_out, -1);
        else begin
          logic [DW-1:0] e;
          e = exp_tx.pop_front();
          check(bus_out == e, "R5 written byte", bus_out, e);
        end
      end
      if (!prev_wr && ext_wr_n) check(wr_w == STROBE_W, "R6 write strobe width", wr_w, STROBE_W);
      wr_w = !ext_wr_n ? wr_w + 1 : 0;
      if (!bus_oe) setup_w = 0; else if (ext_wr_n) setup_w++;

      if (!prev_act && (!ext_rd_n || !ext_wr_n || bus_oe))
        check(idle_cnt >= HOLD_W + 1, "R4 quiet gap", idle_cnt, HOLD_W + 1);
      prev_act = !ext_rd_n || !ext_wr_n || bus_oe;
      idle_cnt = prev_act ? 0 : idle_cnt + 1;

      if (bus_oe && !ext_rd_n) viol_r7++;
      if (!ext_rd_n && !ext_wr_n) viol_r10++;

      if (rx_valid && rx_ready) begin
        if (exp_rx.size() == 0) check(0, "R2 unexpected byte", rx_data, -1);
        else begin
          logic [DW-1:0] e;
          e = exp_rx.pop_front();
          check(rx_data == e, "R2 received byte", rx_data, e);
        end
      end

      if (!prev_fl && ext_flush_n) begin
        pulses++;
        check(fl_w == PULSE_W, "R9 flush pulse width", fl_w, PULSE_W);
      end
      fl_w = !ext_flush_n ? fl_w + 1 : 0;

      prev_rd = ext_rd_n; prev_wr = ext_wr_n; prev_oe = bus_oe; prev_fl = ext_flush_n;
    end
  end

  task automatic step();
    @(posedge clk);
    #0.5;
  endtask

  task automatic load(input logic [DW-1:0] b);
    dev_q.push_back(b);
    exp_rx.push_back(b);
  endtask

  task automatic send(input logic [DW-1:0] b);
    exp_tx.push_back(b);
    step();
    tx_data  = b;
    tx_valid = 1'b1;
    #0.5;
    while (!tx_ready) step();
    step();
    tx_valid = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int r0;
    int w0;
    // R1: reset state, with demand present on the transmit side
    tx_valid = 1'b1;
    repeat (3) step();
    check(ext_rd_n == 1, "R1 read strobe", ext_rd_n, 1);
    check(ext_wr_n == 1, "R1 write strobe", ext_wr_n, 1);
    check(ext_flush_n == 1, "R1 flush strobe", ext_flush_n, 1);
    check(bus_oe == 0, "R1 bus drive", bus_oe, 0);
    check(rx_valid == 0, "R1 rx_valid", rx_valid, 0);
    check(tx_ready == 0, "R1 tx_ready", tx_ready, 0);
    tx_valid = 1'b0;
    step();
    rst_n = 1'b1;
    repeat (3) step();

    // R2 R3: plain reads
    load(8'h5A); load(8'hC3); load(8'h01);
    while (exp_rx.size() != 0) step();
    repeat (10) step();

    // R5 R6: plain writes
    send(8'h96); send(8'h00); send(8'hFF);
    while (exp_tx.size() != 0) step();
    repeat (10) step();

    // R2: consumer stalls, the byte holds and no further read starts
    rx_ready = 1'b0;
    load(8'hA0); load(8'h3F);
    while (!rx_valid) step();
    r0 = rd_starts;
    repeat (40) step();
    check(rx_valid == 1, "R2 byte held while stalled", rx_valid, 1);
    check(rx_data == 8'hA0, "R2 held byte value", rx_data, 8'hA0);
    check(rd_starts == r0, "R2 no read while output full", rd_starts, r0);
    rx_ready = 1'b1;
    while (exp_rx.size() != 0) step();
    repeat (10) step();

    // R8: both directions busy, starts must alternate
    seq.delete();
    rec = 1'b1;
    load(8'h11); load(8'h22); load(8'h33); load(8'h44);
    fork
      begin
        send(8'hE1); send(8'hE2); send(8'hE3); send(8'hE4);
      end
    join_none
    while (exp_rx.size() != 0 || exp_tx.size() != 0) step();
    repeat (10) step();
    rec = 1'b0;
    check(seq.size() == 8, "R8 start count", seq.size(), 8);
    for (int i = 1; i < seq.size(); i++)
      check(seq[i] != seq[i-1], "R8 alternation", seq[i], seq[i-1] == "R" ? "W" : "R");

    // R5: no write while the space flag is high
    ext_space_n = 1'b1;
    repeat (5) step();
    w0 = wr_starts;
    fork send(8'h77); join_none
    repeat (30) step();
    check(wr_starts == w0, "R5 write held off without space", wr_starts, w0);
    ext_space_n = 1'b0;
    while (exp_tx.size() != 0) step();
    repeat (10) step();

    // R9: single pulse, then a second request made during a pulse is ignored
    step(); flush_req = 1'b1; step(); flush_req = 1'b0;
    repeat (10) step();
    flush_req = 1'b1; step(); flush_req = 1'b0; step();
    flush_req = 1'b1; step(); flush_req = 1'b0;
    repeat (10) step();
    check(pulses == 2, "R9 pulse count", pulses, 2);

    check(viol_r7 == 0, "R7 bus driven during read", viol_r7, 0);
    check(viol_r10 == 0, "R10 strobes overlap", viol_r10, 0);
    check(exp_rx.size() == 0 && exp_tx.size() == 0, "R2 R5 scoreboard drained",
          exp_rx.size() + exp_tx.size(), 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule